// File: doc/BRIEF.md
# Interrupt priority and nesting controller

This block sits next to a processor core and decides which interrupt the core takes next. It handles two kinds of request. One is a non-maskable software trap that is always accepted. The other is a bank of maskable request lines from peripherals or external pins, which are accepted only when the global enable is set. The controller tracks which kind of service routine is running, so maskable routines never nest on each other and only a trap can pre-empt one. It emits a one-cycle acknowledge together with the selected source, and the core uses these to pick a vector.

The global enable bit is held here. Software writes it through a write strobe. Taking a maskable interrupt clears it, and a return-from-interrupt sets it again. While the core runs boot-ROM code, maskable requests are held off without touching the enable bit. Requests whose lines are still asserted when boot-ROM execution ends are then taken. A trap routine is closed by a fixed number of pending-reset strobes, not by a return.

Top module: `inc_nest_ctrl`

## Requirements
- R1: When `trap_req` is high at a clock edge, the following cycle shows `ack`=1 and `ack_is_trap`=1, whatever the state of `gie`, `boot_rom` or any routine in service. `trap_busy` is then 1.
- R2: A trap requested while `trap_busy` is already 1 is acknowledged again and restarts the count of pending-reset strobes.
- R3: While `trap_busy` is 1, no maskable acknowledge (`ack`=1 with `ack_is_trap`=0) is issued.
- R4: While `mask_busy` is 1, no further maskable acknowledge is issued. A trap is still acknowledged, and `mask_busy` stays 1 through the trap routine.
- R5: A `reti` strobe while `trap_busy` is 0 sets `gie` to 1 and clears `mask_busy` in the next cycle. A `reti` strobe while `trap_busy` is 1 has no effect.
- R6: While `boot_rom` is 1, no maskable acknowledge is issued and `gie` keeps its value.
- R7: Request lines are level pending flags. A line still high after `boot_rom` falls is taken once the other conditions allow. A line that rose and fell during boot-ROM execution is not remembered.
- R8: A maskable acknowledge clears `gie` in the same cycle in which `ack` is shown. While `gie` is 0, no maskable acknowledge is issued.
- R9: When several maskable lines are high, the lowest-numbered line wins. Its index appears on `ack_src` as an unsigned binary number during the acknowledge cycle. `ack_src` is 0 in every other cycle.
- R10: `trap_busy` falls only after RPND_NEEDED `rpnd` strobes (2 by default) received while it is high. Fewer strobes leave it set.
- R11: After reset, `ack`, `ack_is_trap`, `ack_src`, `trap_busy`, `mask_busy` and `gie` are all 0.
- R12: A `gie_wr` strobe loads `gie_wdata` into `gie`, unless a maskable acknowledge or an effective `reti` happens in the same cycle. Those take precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Software trap request |
| irq_req | input | N_SRC | Maskable request lines, level pending flags |
| gie_wr | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Value written to the global enable |
| reti | input | 1 | Return-from-interrupt strobe |
| rpnd | input | 1 | Pending-reset strobe that closes a trap routine |
| boot_rom | input | 1 | Core is executing from boot ROM |
| ack | output | 1 | One-cycle interrupt acknowledge |
| ack_is_trap | output | 1 | Acknowledge belongs to the software trap |
| ack_src | output | IDX_W | Index of the acknowledged maskable line |
| trap_busy | output | 1 | Trap routine in service |
| mask_busy | output | 1 | Maskable routine in service |
| gie | output | 1 | Global interrupt enable |

## Verification
The bench builds the block with N_SRC=6 and the default RPND_NEEDED=2. With six lines the index is three bits wide and two codes go unused, so a wrong encoder width or a selection off by one shows up on `ack_src`. The short strobe count means nested traps, a single strobe followed by a re-trap, and complete trap exits all occur many times within the random phase. Directed cases cover boot-ROM masking, the loss of short pulses and the trap that pre-empts a maskable routine.

// File: rtl/inc_pkg.sv
// Shared types for the interrupt nesting controller.
// Assumes nothing beyond a synchronous design context.
package inc_pkg;
    // Decision taken in one cycle by the arbitration logic.
    typedef struct packed {
        logic take_trap;
        logic take_mask;
    } inc_grant_t;
endpackage

// File: rtl/inc_prio_pick.sv
// Lowest-index-first priority picker for the maskable request lines.
// Purely combinational. Assumes N_SRC >= 1.
module inc_prio_pick #(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set line is kept last.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/inc_trap_track.sv
// Tracks a software-trap routine in service. A new trap sets the state
// and restarts the count. RPND_NEEDED pending-reset strobes close it.
// Assumes RPND_NEEDED >= 1.
module inc_trap_track #(
    parameter int RPND_NEEDED = 2,
    localparam int CNT_W = $clog2(RPND_NEEDED + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_trap,
    input  logic rpnd,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    // Busy flag and strobe counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (take_trap) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy && rpnd) begin
            if (cnt == CNT_W'(RPND_NEEDED - 1)) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rpnd && !take_trap) |=> busy); // R10
    AST_TRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> busy); // R2
endmodule

// File: rtl/inc_mask_state.sv
// Holds the global enable and the maskable-in-service flag.
// Priority for the enable: maskable acknowledge, then effective return,
// then software write. Assumes reti_ok is already qualified by trap state.
module inc_mask_state (
    input  logic clk,
    input  logic rst_n,
    input  logic take_mask,
    input  logic reti_ok,
    input  logic gie_wr,
    input  logic gie_wdata,
    output logic mask_busy,
    output logic gie
);
    // Maskable-in-service flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_busy <= 1'b0;
        else if (take_mask) mask_busy <= 1'b1;
        else if (reti_ok)   mask_busy <= 1'b0;
    end

    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)         gie <= 1'b0;
        else if (take_mask) gie <= 1'b0;
        else if (reti_ok)   gie <= 1'b1;
        else if (gie_wr)    gie <= gie_wdata;
    end

    AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_ok && !take_mask) |=> (gie && !mask_busy)); // R5
endmodule

// File: rtl/inc_nest_ctrl.sv
// Interrupt priority and nesting controller (top).
// Accepts a non-maskable trap at any time. Accepts one maskable line,
// lowest index first, only when enabled, outside boot ROM and with no
// routine in service. Acknowledge outputs are registered, one cycle long.
module inc_nest_ctrl #(
    parameter int N_SRC       = 8,
    parameter int RPND_NEEDED = 2,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             gie_wr,
    input  logic             gie_wdata,
    input  logic             reti,
    input  logic             rpnd,
    input  logic             boot_rom,
    output logic             ack,
    output logic             ack_is_trap,
    output logic [IDX_W-1:0] ack_src,
    output logic             trap_busy,
    output logic             mask_busy,
    output logic             gie
);
    import inc_pkg::*;

    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    inc_grant_t       grant;
    logic             reti_ok;

    inc_prio_pick #(.N_SRC(N_SRC)) i_pick (
        .req   (irq_req),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    // Arbitration: the trap always wins; maskable only when fully idle.
    always_comb begin
        grant.take_trap = trap_req;
        grant.take_mask = !trap_req && pick_valid && gie && !boot_rom
                          && !trap_busy && !mask_busy;
    end

    // A return counts only outside a trap routine.
    assign reti_ok = reti && !trap_busy;

    inc_trap_track #(.RPND_NEEDED(RPND_NEEDED)) i_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_trap (grant.take_trap),
        .rpnd      (rpnd),
        .busy      (trap_busy)
    );

    inc_mask_state i_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_mask (grant.take_mask),
        .reti_ok   (reti_ok),
        .gie_wr    (gie_wr),
        .gie_wdata (gie_wdata),
        .mask_busy (mask_busy),
        .gie       (gie)
    );

    // Registered acknowledge and source index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack         <= 1'b0;
            ack_is_trap <= 1'b0;
            ack_src     <= '0;
        end else begin
            ack         <= grant.take_trap || grant.take_mask;
            ack_is_trap <= grant.take_trap;
            ack_src     <= grant.take_mask ? pick_idx : '0;
        end
    end

    AST_TRAP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (ack && ack_is_trap)); // R1
    AST_NO_MASK_IN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_busy |=> !(ack && !ack_is_trap)); // R3
    AST_NO_MASK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        mask_busy |=> !(ack && !ack_is_trap)); // R4
    AST_BOOT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        boot_rom |=> !(ack && !ack_is_trap)); // R6
    AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ack_is_trap) |-> (!gie && mask_busy)); // R8
    AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !(ack && !ack_is_trap)); // R8
    AST_SRC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && !ack_is_trap) |-> (ack_src == '0)); // R9
endmodule

// File: tb/test_inc_nest_ctrl.sv
module test_inc_nest_ctrl;
    localparam int N  = 6;
    localparam int RP = 2;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 1'b0, gie_wr = 1'b0, gie_wdata = 1'b0;
    logic reti = 1'b0, rpnd = 1'b0, boot_rom = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic ack, ack_is_trap, trap_busy, mask_busy, gie;
    logic [IW-1:0] ack_src;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Reference state
    bit m_ack, m_trap, m_tb, m_mb, m_gie;
    int m_src, m_cnt;

    always #5 clk = ~clk;

    inc_nest_ctrl #(.N_SRC(N), .RPND_NEEDED(RP)) i_inc_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata), .reti(reti), .rpnd(rpnd),
        .boot_rom(boot_rom), .ack(ack), .ack_is_trap(ack_is_trap),
        .ack_src(ack_src), .trap_busy(trap_busy), .mask_busy(mask_busy), .gie(gie)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    // Drive one cycle of inputs, advance the model, compare after the edge.
    task automatic step(input bit t, input logic [N-1:0] irq, input bit gw,
                        input bit gd, input bit rt, input bit rp, input bit bt);
        bit take_m, reti_ok;
        trap_req = t; irq_req = irq; gie_wr = gw; gie_wdata = gd;
        reti = rt; rpnd = rp; boot_rom = bt;
        take_m  = !t && (irq != 0) && m_gie && !bt && !m_tb && !m_mb;
        reti_ok = rt && !m_tb;
        m_ack = t || take_m;
        m_trap = t;
        m_src = take_m ? lowest(irq) : 0;
        if (take_m) m_gie = 0; else if (reti_ok) m_gie = 1; else if (gw) m_gie = gd;
        if (take_m) m_mb = 1; else if (reti_ok) m_mb = 0;
        if (t) begin m_tb = 1; m_cnt = 0; end
        else if (m_tb && rp) begin
            if (m_cnt == RP - 1) begin m_tb = 0; m_cnt = 0; end else m_cnt++;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R3 ack", int'(ack), int'(m_ack));
        chk("R1 ack_is_trap", int'(ack_is_trap), int'(m_trap));
        chk("R9 ack_src", int'(ack_src), m_src);
        chk("R10 trap_busy", int'(trap_busy), int'(m_tb));
        chk("R4 mask_busy", int'(mask_busy), int'(m_mb));
        chk("R8 gie", int'(gie), int'(m_gie));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unused;
        unused = $urandom(32'h1D5E_77A1);
        m_ack = 0; m_trap = 0; m_tb = 0; m_mb = 0; m_gie = 0; m_src = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 ack", int'(ack), 0);
        chk("R11 trap_busy", int'(trap_busy), 0);
        chk("R11 mask_busy", int'(mask_busy), 0);
        chk("R11 gie", int'(gie), 0);
        chk("R11 ack_src", int'(ack_src), 0);
        // R8: with gie low a request is not taken
        step(0, 6'b000001, 0, 0, 0, 0, 0);
        chk("R8 gated", int'(ack), 0);
        // R12: software write sets gie
        step(0, 0, 1, 1, 0, 0, 0);
        chk("R12 gie write", int'(gie), 1);
        // R9: lowest line wins
        step(0, 6'b101100, 0, 0, 0, 0, 0);
        chk("R9 src", int'(ack_src), 2);
        chk("R8 gie cleared", int'(gie), 0);
        // R4: no nesting even with gie forced back on
        step(0, 6'b101100, 1, 1, 0, 0, 0);
        step(0, 6'b101100, 0, 0, 0, 0, 0);
        chk("R4 no nest", int'(ack), 0);
        // R4/R1: trap pre-empts a maskable routine
        step(1, 6'b000001, 0, 0, 0, 0, 0);
        chk("R1 trap ack", int'(ack && ack_is_trap), 1);
        chk("R4 mask kept", int'(mask_busy), 1);
        // R5: reti during trap ignored
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R5 reti ignored", int'(mask_busy), 1);
        // R10: one strobe is not enough; R2: re-trap restarts count
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R10 one strobe", int'(trap_busy), 1);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R2 restarted", int'(trap_busy), 1);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R10 cleared", int'(trap_busy), 0);
        // R5: effective reti
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R5 gie", int'(gie), 1);
        chk("R5 mask_busy", int'(mask_busy), 0);
        // R6: boot ROM blocks and keeps gie; R7: short pulse lost
        step(0, 6'b000001, 0, 0, 0, 0, 1);
        chk("R6 blocked", int'(ack), 0);
        chk("R6 gie kept", int'(gie), 1);
        step(0, 6'b001000, 0, 0, 0, 0, 1);
        step(0, 6'b001000, 0, 0, 0, 0, 0);
        chk("R7 held line taken", int'(ack_src), 3);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 6'b000000, 0, 0, 0, 0, 0);
        chk("R7 pulse lost", int'(ack), 0);
        // Random phase
        for (int k = 0; k < 4000; k++) begin
            bit t, gw, gd, rt, rp, bt;
            logic [N-1:0] irq;
            t  = ($urandom % 100) < 4;
            gw = ($urandom % 100) < 8;
            gd = $urandom % 2;
            rt = ($urandom % 100) < 12;
            rp = ($urandom % 100) < 20;
            bt = ($urandom % 100) < 15;
            irq = N'($urandom);
            if (($urandom % 4) == 0) irq = '0;
            step(t, irq, gw, gd, rt, rp, bt);
        end
        finish_run();
    end
endmodule